// File: doc/BRIEF.md
# Memory-Mapped Multiply-Accumulate Peripheral

This block is a multiplier that a processor reaches through a small word-wide register bus. Software writes the first operand to one of four addresses. The address it uses selects the operation: unsigned multiply, signed multiply, unsigned accumulate or signed accumulate. Software then writes the second operand, and that write alone starts the computation. No start bit exists. The first operand and the chosen operation stay stored, so a stream of second-operand writes reuses them. This makes a dot product a plain sequence of data writes.

The product, or the running sum in the accumulate modes, is held as a double-width result. Software reads it back as a low word and a high word. A third, read-only word carries the extension of the result: the sign fill for the signed modes, or the carry out of the sum for unsigned accumulation. Software may write the two result words, which preloads the accumulator before an accumulate sequence. Every register updates on the clock edge that ends the bus write, so a read in the very next cycle returns the new value.

Top module: `mmac_unit`

## Requirements
- R1: After reset, every readable word returns 0 and the stored operation is unsigned multiply.
- R2: A write to word offset 0x0, 0x2, 0x4 or 0x6 stores the first operand and selects, in that order, unsigned multiply, signed multiply, unsigned accumulate or signed accumulate. A read of any of these four offsets returns the stored first operand.
- R3: A write to offset 0x8 stores the second operand, which reads back at 0x8, and launches the selected operation. The low result word at 0xA, the high result word at 0xC and the extension word at 0xE return the new values on a read in the cycle that directly follows the write. They hold their values until the next launch or preload.
- R4: Unsigned multiply puts the 32-bit unsigned product in the result words, and the extension word reads 0x0000.
- R5: Signed multiply puts the 32-bit two's-complement product in the result words. The extension word reads 0xFFFF when the product is negative and 0x0000 otherwise.
- R6: Unsigned accumulate adds the unsigned product to the 32-bit value in the result words, keeping the sum modulo 2^32. The extension word reads 1 when that addition carries out of bit 31 and 0 otherwise.
- R7: Signed accumulate adds the signed product to the 32-bit value in the result words, keeping the sum modulo 2^32. The extension word is bit 31 of the new sum copied into all 16 bits.
- R8: A write to 0xA or 0xC loads that result word directly, so software can preload the accumulator. The extension word does not change.
- R9: The extension word at 0xE is read-only: a write to it changes no readable word.
- R10: The first operand and the selected operation keep their values across any number of second-operand writes, until the next write to 0x0–0x6.
- R11: A cycle with the select input low changes no register, whatever the write-enable, address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the accessed word; bit 0 is ignored |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for the word at bus_addr, combinational from the registers |

## Verification
The bench builds two copies of the block with the default 16-bit word and 4-bit byte address. Both copies sit on the same bus. One uses the single shared sign-extended multiplier and the other uses separate signed and unsigned multipliers. Every read is scored against one model, so both multiplier variants are covered by the same operand corners: 0xFFFF squared, 0x8000 squared, minus one times one, and carry wrap of a preloaded all-ones accumulator. A pseudo-random operand stream cycles through all four modes.

// File: rtl/mmac_pkg.sv
package mmac_pkg;

   // Operation chosen by which first-operand word is written (word index 0..3).
   typedef enum logic [1:0] {
      OP_UMUL = 2'd0,
      OP_SMUL = 2'd1,
      OP_UMAC = 2'd2,
      OP_SMAC = 2'd3
   } mmac_op_e;

   // Width of the word index taken from the byte address.
   localparam int unsigned IDX_W = 3;

   // Word indices of the non-operand-A registers.
   localparam logic [IDX_W-1:0] WIDX_OPB = 3'd4;
   localparam logic [IDX_W-1:0] WIDX_RLO = 3'd5;
   localparam logic [IDX_W-1:0] WIDX_RHI = 3'd6;
   localparam logic [IDX_W-1:0] WIDX_EXT = 3'd7;

   function automatic logic op_signed(input mmac_op_e op);
      return op[0];
   endfunction

   function automatic logic op_accum(input mmac_op_e op);
      return op[1];
   endfunction

endpackage

// File: rtl/mmac_decode.sv
module mmac_decode
   import mmac_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int ADDR_LSB = 1
) (
   input  logic              sel,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   output logic              wr_opa,
   output mmac_op_e          wr_op,
   output logic              wr_opb,
   output logic              wr_lo,
   output logic              wr_hi,
   output logic              wr_ext,
   output logic [IDX_W-1:0]  idx
);

   localparam int IDX_SPAN = ADDR_W - ADDR_LSB;

   generate
      if (IDX_SPAN != IDX_W) begin : g_bad_span
         $error("mmac_decode: ADDR_W-ADDR_LSB must equal %0d", IDX_W);
      end
      if (ADDR_LSB > 0) begin : g_lsb
         logic unused_lsb;
         assign unused_lsb = ^addr[ADDR_LSB-1:0];
      end
   endgenerate

   logic wr;

   always_comb begin
      idx    = addr[ADDR_LSB +: IDX_W];
      wr     = sel & we;
      // Upper half of the map is operand B and the result words.
      wr_opa = wr & ~idx[IDX_W-1];
      wr_op  = mmac_op_e'(idx[1:0]);
      wr_opb = wr & (idx == WIDX_OPB);
      wr_lo  = wr & (idx == WIDX_RLO);
      wr_hi  = wr & (idx == WIDX_RHI);
      wr_ext = wr & (idx == WIDX_EXT);
   end

endmodule

// File: rtl/mmac_arith.sv
module mmac_arith
   import mmac_pkg::*;
#(
   parameter int DW          = 16,
   parameter bit SHARED_MULT = 1'b1
) (
   input  logic [DW-1:0]   opa,
   input  logic [DW-1:0]   opb,
   input  mmac_op_e        op,
   input  logic [2*DW-1:0] acc,
   output logic [2*DW-1:0] res,
   output logic [DW-1:0]   ext
);

   localparam int RW = 2 * DW;

   logic [RW-1:0] prod;
   logic          sgn;

   assign sgn = op_signed(op);

   generate
      if (SHARED_MULT) begin : g_shared
         // One RW x RW multiplier; extending the operands by the mode picks
         // signed or unsigned, and the low RW bits are exact in both cases.
         logic [RW-1:0] a_w;
         logic [RW-1:0] b_w;
         assign a_w  = {{DW{sgn & opa[DW-1]}}, opa};
         assign b_w  = {{DW{sgn & opb[DW-1]}}, opb};
         assign prod = a_w * b_w;
      end else begin : g_split
         logic [RW-1:0] p_u;
         logic [RW-1:0] p_s;
         assign p_u  = RW'(opa) * RW'(opb);
         assign p_s  = RW'($signed(opa)) * RW'($signed(opb));
         assign prod = sgn ? p_s : p_u;
      end
   endgenerate

   logic [RW:0] sum;
   assign sum = {1'b0, acc} + {1'b0, prod};

   always_comb begin
      unique case (op)
         OP_UMUL: begin
            res = prod;
            ext = '0;
         end
         OP_SMUL: begin
            res = prod;
            ext = {DW{prod[RW-1]}};
         end
         OP_UMAC: begin
            res = sum[RW-1:0];
            ext = {{(DW-1){1'b0}}, sum[RW]};
         end
         default: begin
            res = sum[RW-1:0];
            ext = {DW{sum[RW-1]}};
         end
      endcase
   end

endmodule

// File: rtl/mmac_rdmux.sv
module mmac_rdmux
   import mmac_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [DW-1:0]    opa,
   input  logic [DW-1:0]    opb,
   input  logic [DW-1:0]    res_lo,
   input  logic [DW-1:0]    res_hi,
   input  logic [DW-1:0]    ext,
   output logic [DW-1:0]    rdata
);

   always_comb begin
      unique case (idx)
         WIDX_OPB: rdata = opb;
         WIDX_RLO: rdata = res_lo;
         WIDX_RHI: rdata = res_hi;
         WIDX_EXT: rdata = ext;
         default:  rdata = opa;
      endcase
   end

endmodule

// File: rtl/mmac_unit.sv
module mmac_unit
   import mmac_pkg::*;
#(
   parameter int DW          = 16,
   parameter int ADDR_W      = 4,
   parameter int ADDR_LSB    = 1,
   parameter bit SHARED_MULT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata
);

   localparam int RW = 2 * DW;

   generate
      if (DW < 2) begin : g_bad_dw
         $error("mmac_unit: DW must be at least 2");
      end
   endgenerate

   logic             wr_opa, wr_opb, wr_lo, wr_hi, wr_ext;
   mmac_op_e         wr_op;
   logic [IDX_W-1:0] idx;

   mmac_decode #(.ADDR_W(ADDR_W), .ADDR_LSB(ADDR_LSB)) u_decode (
      .sel    (bus_sel),
      .we     (bus_we),
      .addr   (bus_addr),
      .wr_opa (wr_opa),
      .wr_op  (wr_op),
      .wr_opb (wr_opb),
      .wr_lo  (wr_lo),
      .wr_hi  (wr_hi),
      .wr_ext (wr_ext),
      .idx    (idx)
   );

   logic [DW-1:0] opa_q, opb_q, res_lo_q, res_hi_q, ext_q;
   mmac_op_e      op_q;

   // The new operand B feeds the datapath directly, so the result lands in
   // the same edge that captures the operand.
   logic [RW-1:0] nxt_res;
   logic [DW-1:0] nxt_ext;

   mmac_arith #(.DW(DW), .SHARED_MULT(SHARED_MULT)) u_arith (
      .opa (opa_q),
      .opb (bus_wdata),
      .op  (op_q),
      .acc ({res_hi_q, res_lo_q}),
      .res (nxt_res),
      .ext (nxt_ext)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opa_q <= '0;
         op_q  <= OP_UMUL;
      end else if (wr_opa) begin
         opa_q <= bus_wdata;
         op_q  <= wr_op;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opb_q    <= '0;
         res_lo_q <= '0;
         res_hi_q <= '0;
         ext_q    <= '0;
      end else if (wr_opb) begin
         opb_q    <= bus_wdata;
         res_lo_q <= nxt_res[DW-1:0];
         res_hi_q <= nxt_res[RW-1:DW];
         ext_q    <= nxt_ext;
      end else if (wr_lo) begin
         res_lo_q <= bus_wdata;
      end else if (wr_hi) begin
         res_hi_q <= bus_wdata;
      end
   end

   mmac_rdmux #(.DW(DW)) u_rdmux (
      .idx    (idx),
      .opa    (opa_q),
      .opb    (opb_q),
      .res_lo (res_lo_q),
      .res_hi (res_hi_q),
      .ext    (ext_q),
      .rdata  (bus_rdata)
   );

   // ---------------- assertions ----------------
   p_launch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_opb && !wr_lo && !wr_hi) |=> ($stable(res_lo_q) && $stable(res_hi_q) && $stable(ext_q)));

   p_umul_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_opb && op_q == OP_UMUL) |=> (ext_q == '0));

   p_smul_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_opb && op_q == OP_SMUL) |=> (ext_q == {DW{res_hi_q[DW-1]}}));

   p_umac_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_opb && op_q == OP_UMAC) |=> ((ext_q >> 1) == '0));

   p_smac_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_opb && op_q == OP_SMAC) |=> (ext_q == {DW{res_hi_q[DW-1]}}));

   p_preload_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (res_lo_q == $past(bus_wdata) && $stable(ext_q)));

   p_ext_readonly_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ext |=> ($stable(ext_q) && $stable(res_lo_q) && $stable(res_hi_q)));

   p_opa_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_opa |=> ($stable(opa_q) && $stable(op_q)));

   p_unselected_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |=> ($stable(opb_q) && $stable(res_lo_q) && $stable(res_hi_q) && $stable(opa_q)));

endmodule

// File: tb/mmac_unit_bench.sv
`timescale 1ns/1ps
module mmac_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_sel, bus_we;
   logic [3:0]  bus_addr;
   logic [15:0] bus_wdata;
   logic [15:0] rdata_a, rdata_b;

   always #2.5 clk = ~clk;

   mmac_unit #(.SHARED_MULT(1'b1)) u_mmac_unit (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a));

   mmac_unit #(.SHARED_MULT(1'b0)) u_mmac_split (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b));

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   // Scoreboard queues filled by the driver, drained by the monitor.
   logic [15:0] exp_q[$];
   string       tag_q[$];

   // Reference model state.
   logic [15:0] m_opa, m_opb, m_lo, m_hi, m_ext;
   logic [1:0]  m_mode;

   function automatic void model_launch();
      logic [31:0]        acc;
      logic [63:0]        u;
      logic signed [63:0] s;
      logic [31:0]        r;
      acc = {m_hi, m_lo};
      case (m_mode)
         2'd0: begin
            u = 64'(m_opa) * 64'(m_opb);
            r = u[31:0]; m_ext = 16'h0000;
         end
         2'd1: begin
            s = 64'($signed(m_opa)) * 64'($signed(m_opb));
            r = s[31:0]; m_ext = (s < 0) ? 16'hFFFF : 16'h0000;
         end
         2'd2: begin
            u = 64'(acc) + 64'(m_opa) * 64'(m_opb);
            r = u[31:0]; m_ext = u[32] ? 16'h0001 : 16'h0000;
         end
         default: begin
            s = 64'($signed(acc)) + 64'($signed(m_opa)) * 64'($signed(m_opb));
            r = s[31:0]; m_ext = r[31] ? 16'hFFFF : 16'h0000;
         end
      endcase
      m_lo = r[15:0];
      m_hi = r[31:16];
   endfunction

   function automatic void model_write(input logic [3:0] a, input logic [15:0] d);
      case (a[3:1])
         3'd0, 3'd1, 3'd2, 3'd3: begin m_opa = d; m_mode = a[2:1]; end
         3'd4: begin m_opb = d; model_launch(); end
         3'd5: m_lo = d;
         3'd6: m_hi = d;
         default: ;
      endcase
   endfunction

   function automatic logic [15:0] model_read(input logic [3:0] a);
      case (a[3:1])
         3'd4: return m_opb;
         3'd5: return m_lo;
         3'd6: return m_hi;
         3'd7: return m_ext;
         default: return m_opa;
      endcase
   endfunction

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      model_write(a, d);
   endtask

   task automatic rd(input logic [3:0] a, input string tag);
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wdata = 16'hDEAD;
      exp_q.push_back(model_read(a));
      tag_q.push_back(tag);
   endtask

   task automatic unsel_wr(input logic [3:0] a, input logic [15:0] d);
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
   endtask

   task automatic idle();
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   // Monitor: scores every read away from the active edge.
   always @(negedge clk) begin
      if (rst_n && bus_sel && !bus_we) begin
         logic [15:0] e;
         string       t;
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: read with no expected item, actual=%h expected=none", rdata_a);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdata_a !== e) begin
               errors++;
               $display("FAIL %s shared-mult addr=%h actual=%h expected=%h", t, bus_addr, rdata_a, e);
            end
            checks++;
            if (rdata_b !== e) begin
               errors++;
               $display("FAIL %s split-mult addr=%h actual=%h expected=%h", t, bus_addr, rdata_b, e);
            end
         end
      end
   end

   // Watchdog.
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   function automatic string mode_tag(input int m);
      case (m)
         0: return "R4";
         1: return "R5";
         2: return "R6";
         default: return "R7";
      endcase
   endfunction

   initial begin
      logic [15:0] lf;
      bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
      m_opa = '0; m_opb = '0; m_lo = '0; m_hi = '0; m_ext = '0; m_mode = 2'd0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: every word zero after reset
      for (int a = 0; a < 16; a += 2) rd(4'(a), "R1");
      // R1: reset mode is unsigned multiply
      wr(4'h8, 16'h0003);
      rd(4'hA, "R1");
      rd(4'hE, "R1");

      // R2: operand A store and read-back at all four mode offsets
      wr(4'h0, 16'h1234);
      rd(4'h0, "R2"); rd(4'h2, "R2"); rd(4'h4, "R2"); rd(4'h6, "R2");

      // R3/R4: launch and read on the very next cycle
      wr(4'h8, 16'h0010);
      rd(4'hA, "R3"); rd(4'hC, "R3"); rd(4'hE, "R4"); rd(4'h8, "R3");
      // R10: reuse of held operand A
      wr(4'h8, 16'hFFFF);
      rd(4'hA, "R10"); rd(4'hC, "R10"); rd(4'h0, "R10");
      // R4: largest unsigned product
      wr(4'h0, 16'hFFFF); wr(4'h8, 16'hFFFF);
      rd(4'hA, "R4"); rd(4'hC, "R4"); rd(4'hE, "R4");

      // R5: signed multiply corners
      wr(4'h2, 16'hFFFF); wr(4'h8, 16'h0001);
      rd(4'hA, "R5"); rd(4'hC, "R5"); rd(4'hE, "R5");
      wr(4'h8, 16'hFFFF);
      rd(4'hA, "R5"); rd(4'hC, "R5"); rd(4'hE, "R5");
      wr(4'h2, 16'h8000); wr(4'h8, 16'h8000);
      rd(4'hC, "R5"); rd(4'hE, "R5");

      // R8: preload, extension untouched
      wr(4'hA, 16'hFFFF); wr(4'hC, 16'hFFFF);
      rd(4'hA, "R8"); rd(4'hC, "R8"); rd(4'hE, "R8");
      // R6: carry out of a preloaded all-ones accumulator
      wr(4'h4, 16'h0001); wr(4'h8, 16'h0001);
      rd(4'hA, "R6"); rd(4'hC, "R6"); rd(4'hE, "R6");
      wr(4'h8, 16'h0003);
      rd(4'hA, "R6"); rd(4'hE, "R6");

      // R7: signed accumulate crossing zero
      wr(4'hA, 16'h0005); wr(4'hC, 16'h0000);
      wr(4'h6, 16'hFFFE); wr(4'h8, 16'h0003);
      rd(4'hA, "R7"); rd(4'hC, "R7"); rd(4'hE, "R7");
      wr(4'h8, 16'hFFFF);
      rd(4'hA, "R7"); rd(4'hE, "R7");

      // R9: extension word ignores writes
      wr(4'hE, 16'h1234);
      rd(4'hE, "R9"); rd(4'hA, "R9"); rd(4'hC, "R9");

      // R11: unselected write cycles do nothing
      unsel_wr(4'h8, 16'h7777);
      unsel_wr(4'h0, 16'h5555);
      unsel_wr(4'hA, 16'h3333);
      rd(4'hA, "R11"); rd(4'hC, "R11"); rd(4'h8, "R11"); rd(4'h0, "R11");

      // Mixed stream across all modes
      lf = 16'hACE1;
      for (int i = 0; i < 48; i++) begin
         logic [15:0] x;
         x = lf;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         if (i % 8 == 0) begin
            wr(4'hA, x ^ 16'h5A5A);
            wr(4'hC, lf);
         end
         wr(4'(2 * (i % 4)), x);
         wr(4'h8, lf);
         rd(4'hA, mode_tag(i % 4));
         rd(4'hC, mode_tag(i % 4));
         rd(4'hE, mode_tag(i % 4));
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      end

      idle();
      repeat (3) @(posedge clk);
      if (exp_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL scoreboard: items left, actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule